// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a 32-bit down-counting timer reached through a small word-addressed register bus. Software picks one of three incoming tick enables, or none, and a prescaler divides the chosen tick. The divided tick decrements the counter. When the counter is at zero, the next step either reloads it from a load register or wraps it to all-ones. A compare register is watched on every step. When a step lands the counter on the compare value, a sticky flag is set. That flag drives a level interrupt once the interrupt is unmasked and the timer is enabled.

The counter can be preloaded in two ways. The first is a rising edge of the enable bit while the enable-mode bit is set. The second is a load-register write while the immediate-overwrite bit is set. A control bit triggers a soft reset, which keeps the enable and low-power bits and returns the rest of the block to its reset values. The low-power bits are only stored. Clock generation, bus fabric and interrupt routing are outside the block.

Top module: `pit_timer`

## Requirements
- R1: After hard reset, control reads 0, status 0, load 0xFFFFFFFF, compare 0, count 0xFFFFFFFF, and the interrupt is low.
- R2: Word offsets are 0 control, 1 status, 2 load, 3 compare and 4 count. Count cannot be written. A write to offset 4 to 7 changes nothing, and a read of offset 5 to 7 returns 0.
- R3: A control write keeps bits 25:0 only. Bits 31:26 always read 0.
- R4: Control bits 25:24 select the decrement source: 0 none (counter frozen even when enabled), 1 `tick_periph`, 2 `tick_fast`, 3 `tick_slow`. Control bit 0 enables counting.
- R5: With control bits 15:4 holding N, the counter steps once per N+1 selected ticks.
- R6: With control bit 3 (reload) set, a step taken at zero loads the counter from the load register.
- R7: With control bit 3 clear, a step taken at zero wraps the counter to 0xFFFFFFFF.
- R8: A control write that sets bit 0 while bit 0 was clear, and that also has bit 1 (enable-mode) set, loads the counter in the same cycle. The value is the load register when the written bit 3 is set, and 0xFFFFFFFF otherwise.
- R9: A load-register write while control bit 17 is set also writes the counter with the same value, in either counting mode.
- R10: Status bit 0 is set by a step whose new counter value equals the compare register. This happens whether or not the interrupt is enabled.
- R11: `irq` is high exactly when status bit 0, control bit 2 (interrupt enable) and control bit 0 are all set.
- R12: Writing status with bit 0 = 1 clears the flag, and writing 0 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R13: A control write with bit 16 set is a soft reset. Control keeps only the written bits 0, 1 and 21:18, and bit 16 reads back 0. Status and compare become 0, load becomes 0xFFFFFFFF, and the counter becomes 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_periph | input | 1 | Decrement source 1 tick enable |
| tick_fast | input | 1 | Decrement source 2 tick enable |
| tick_slow | input | 1 | Decrement source 3 tick enable |
| irq | output | 1 | Level compare interrupt |

## Verification
The bench lines a status clear up with the same cycle as a compare match. A design where the clear has priority would lose that interrupt, and the flag would read 0. It follows the counter step by step through the zero boundary in both counting modes. An off-by-one in the reload or wrap path shows up there as a wrong value or a skipped count. It enables the timer with the clock source set to none, and with a source whose tick stays low. A design that counted anyway would show a moving count. It also fires a soft reset with every control bit set, so a wrong keep mask, or a reset bit that sticks, shows up directly in the control readback.

// File: rtl/pit_pkg.sv
// pit_pkg: shared constants for the periodic timer.
// Holds control bit positions, register offsets, clock source codes and the
// mask of control bits that survive a soft reset.
package pit_pkg;

    localparam int CR_W     = 26;   // stored control width
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_IE     = 2;
    localparam int B_RLD    = 3;
    localparam int PRE_LSB  = 4;
    localparam int PRE_W    = 12;
    localparam int B_SWR    = 16;
    localparam int B_IOVW   = 17;
    localparam int LP_LSB   = 18;   // debug, wait, doze, stop enables
    localparam int LP_W     = 4;
    localparam int SRC_LSB  = 24;
    localparam int SRC_W    = 2;

    // Bits of the written control word kept by a soft reset.
    localparam logic [CR_W-1:0] SOFT_KEEP =
        CR_W'((1 << B_EN) | (1 << B_ENMOD) | (((1 << LP_W) - 1) << LP_LSB));

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_STAT = 3'd1,
        OFF_LOAD = 3'd2,
        OFF_CMP  = 3'd3,
        OFF_CNT  = 3'd4
    } reg_off_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 2'd0,
        SRC_PERIPH = 2'd1,
        SRC_FAST   = 2'd2,
        SRC_SLOW   = 2'd3
    } clk_src_e;

endpackage

// File: rtl/pit_tick_gen.sv
// pit_tick_gen: picks one tick enable by the source code and divides it by
// presc+1. Emits a one-cycle step pulse.
// Assumes tick inputs are synchronous to clk. The divider phase restarts
// whenever counting is off, or on a soft reset.
module pit_tick_gen
    import pit_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             enable,
    input  logic [SRC_W-1:0] src,
    input  logic [PW-1:0]    presc,
    input  logic             tick_periph,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic             step
);

    logic          tick_sel;
    logic          run;
    logic [PW-1:0] pre_cnt;

    // Select the tick enable named by the source code.
    always_comb begin
        unique case (clk_src_e'(src))
            SRC_PERIPH: tick_sel = tick_periph;
            SRC_FAST:   tick_sel = tick_fast;
            SRC_SLOW:   tick_sel = tick_slow;
            default:    tick_sel = 1'b0;
        endcase
    end

    assign run  = enable && (src != SRC_NONE);
    assign step = run && tick_sel && (pre_cnt >= presc);

    // Count selected ticks up to the prescale limit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !run) begin
            pre_cnt <= '0;
        end else if (tick_sel) begin
            pre_cnt <= (pre_cnt >= presc) ? '0 : pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pit_count_core.sv
// pit_count_core: the down counter and its compare detector.
// A load request wins over a step, and a soft reset wins over both.
// hit marks a step whose new count equals the compare value.
module pit_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         reload_mode,
    input  logic [W-1:0] load_reg,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         hit
);

    logic [W-1:0] cnt_nxt;

    // Value after one step: reload or wrap at zero, otherwise decrement.
    always_comb begin
        if (cnt == '0) begin
            cnt_nxt = reload_mode ? load_reg : '1;
        end else begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    assign hit = step && !load_en && !soft_rst && (cnt_nxt == cmp_val);

    // Counter register with reset, preload and step.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt <= '1;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/pit_regs.sv
// pit_regs: register file for the timer. Decodes bus writes, keeps control,
// flag, load and compare, raises preload and soft reset requests, muxes
// readback and forms the interrupt.
// Assumes one write per cycle, and that the read data is sampled
// combinationally.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              hit,
    output logic              soft_rst,
    output logic              load_en,
    output logic [DATA_W-1:0] load_val,
    output logic              run_en,
    output logic [SRC_W-1:0]  src,
    output logic [PRE_W-1:0]  presc,
    output logic              reload_mode,
    output logic [DATA_W-1:0] load_reg,
    output logic [DATA_W-1:0] cmp_val,
    output logic              flag,
    output logic              irq
);

    logic [CR_W-1:0] ctrl_q;
    logic [CR_W-1:0] wr_cr;
    logic            wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic            en_rise;
    logic            lr_now;

    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_load = bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
    assign wr_cmp  = bus_we && (bus_addr == ADDR_W'(OFF_CMP));
    assign wr_cr   = bus_wdata[CR_W-1:0];

    assign soft_rst = wr_ctrl && wr_cr[B_SWR];
    assign en_rise  = wr_ctrl && !wr_cr[B_SWR] && wr_cr[B_EN] &&
                      !ctrl_q[B_EN] && wr_cr[B_ENMOD];
    assign lr_now   = wr_load && ctrl_q[B_IOVW];

    // Preload request and its value: enable edge or immediate load write.
    always_comb begin
        load_en  = en_rise || lr_now;
        load_val = bus_wdata;
        if (en_rise) begin
            load_val = wr_cr[B_RLD] ? load_reg : '1;
        end
    end

    // Control register: store the low bits, or keep a subset on soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_cr[B_SWR] ? (wr_cr & SOFT_KEEP) : wr_cr;
        end
    end

    // Load register: all-ones after either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            load_reg <= '1;
        end else if (wr_load) begin
            load_reg <= bus_wdata;
        end
    end

    // Compare register: zero after either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cmp_val <= '0;
        end else if (wr_cmp) begin
            cmp_val <= bus_wdata;
        end
    end

    // Sticky compare flag: a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            flag <= 1'b0;
        end
    end

    // Readback multiplexer. Unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CTRL): bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(OFF_STAT): bus_rdata = DATA_W'(flag);
            ADDR_W'(OFF_LOAD): bus_rdata = load_reg;
            ADDR_W'(OFF_CMP):  bus_rdata = cmp_val;
            ADDR_W'(OFF_CNT):  bus_rdata = cnt;
            default:           bus_rdata = '0;
        endcase
    end

    assign run_en      = ctrl_q[B_EN];
    assign src         = ctrl_q[SRC_LSB +: SRC_W];
    assign presc       = ctrl_q[PRE_LSB +: PRE_W];
    assign reload_mode = ctrl_q[B_RLD];
    assign irq         = flag && ctrl_q[B_IE] && ctrl_q[B_EN];

endmodule

// File: rtl/pit_timer.sv
// pit_timer: top of the periodic down-counter timer. Joins the register file,
// the tick selector and divider, and the counter core.
// Assumes DATA_W is 32 so the control layout fits, and ADDR_W >= 3.
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_periph,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              irq
);

    logic              soft_rst;
    logic              load_en;
    logic [DATA_W-1:0] load_val;
    logic              run_en;
    logic [SRC_W-1:0]  clk_src;
    logic [PRE_W-1:0]  presc;
    logic              reload_mode;
    logic [DATA_W-1:0] lr_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] cnt_q;
    logic              flag_q;
    logic              hit;
    logic              step;

    pit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt         (cnt_q),
        .hit         (hit),
        .soft_rst    (soft_rst),
        .load_en     (load_en),
        .load_val    (load_val),
        .run_en      (run_en),
        .src         (clk_src),
        .presc       (presc),
        .reload_mode (reload_mode),
        .load_reg    (lr_q),
        .cmp_val     (cmp_q),
        .flag        (flag_q),
        .irq         (irq)
    );

    pit_tick_gen #(.PW(PRE_W)) tick_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .enable      (run_en),
        .src         (clk_src),
        .presc       (presc),
        .tick_periph (tick_periph),
        .tick_fast   (tick_fast),
        .tick_slow   (tick_slow),
        .step        (step)
    );

    pit_count_core #(.W(DATA_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .load_en     (load_en),
        .load_val    (load_val),
        .step        (step),
        .reload_mode (reload_mode),
        .load_reg    (lr_q),
        .cmp_val     (cmp_q),
        .cnt         (cnt_q),
        .hit         (hit)
    );

endmodule

// File: rtl/pit_timer_chk.sv
// pit_timer_chk: temporal checks on the timer, bound into pit_timer.
// Observes bus inputs together with state held in different submodules.
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              run_en,
    input logic [SRC_W-1:0]  clk_src,
    input logic              reload_mode,
    input logic              step,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] cmp_q,
    input logic [DATA_W-1:0] lr_q,
    input logic              flag_q
);

    // R4: with counting off and no bus write, the count holds.
    a_r4_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && (!run_en || clk_src == SRC_NONE)) |=> $stable(cnt_q));

    // R6: a step at zero in reload mode lands on the load value.
    a_r6_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0 && reload_mode && !bus_we) |=> (cnt_q == $past(lr_q)));

    // R7: a step at zero in free-run mode lands on all-ones.
    a_r7_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0 && !reload_mode && !bus_we) |=> (cnt_q == '1));

    // R10: the flag only rises on a count that matches the compare value.
    a_r10_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (cnt_q == $past(cmp_q)));

    // R12: the flag stays set unless cleared or soft-reset.
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q &&
         !(bus_we && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0]) &&
         !(bus_we && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[B_SWR]))
        |=> flag_q);

endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .run_en      (run_en),
    .clk_src     (clk_src),
    .reload_mode (reload_mode),
    .step        (step),
    .cnt_q       (cnt_q),
    .cmp_q       (cmp_q),
    .lr_q        (lr_q),
    .flag_q      (flag_q)
);

// File: tb/pit_timer_tb_top.sv
// pit_timer_tb_top: directed bench for the periodic timer, one task per scenario.
module pit_timer_tb_top;

    localparam logic [31:0] C_EN   = 32'h1;
    localparam logic [31:0] C_ENM  = 32'h2;
    localparam logic [31:0] C_IE   = 32'h4;
    localparam logic [31:0] C_RLD  = 32'h8;
    localparam logic [31:0] C_SWR  = 32'h1_0000;
    localparam logic [31:0] C_IOVW = 32'h2_0000;
    localparam logic [31:0] C_LP   = 32'h3C_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_periph = 1'b0;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pit_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tick_periph (tick_periph),
        .tick_fast   (tick_fast),
        .tick_slow   (tick_slow),
        .irq         (irq)
    );

    function automatic logic [31:0] c_pre(input int n);
        return 32'(n) << 4;
    endfunction

    function automatic logic [31:0] c_src(input int s);
        return 32'(s) << 24;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] c_spin(input int n);
        return 32'(n);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 ctrl", v, 32'h0);
        rd(3'd1, v); check("R1 status", v, 32'h0);
        rd(3'd2, v); check("R1 load", v, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R1 compare", v, 32'h0);
        rd(3'd4, v); check("R1 count", v, 32'hFFFF_FFFF);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(3'd0, 32'hFFFE_FFFE);
        rd(3'd0, v); check("R3 ctrl upper bits", v, 32'h03FE_FFFE);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0000_1234);
        rd(3'd4, v); check("R2 count read-only", v, 32'hFFFF_FFFF);
        wr(3'd5, 32'hAAAA_5555);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); check("R2 unmapped read", v, 32'h0);
        end
        rd(3'd2, v); check("R2 load untouched", v, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R2 compare untouched", v, 32'h0);
    endtask

    task automatic t_sources();
        logic [31:0] v, c0;
        tick_periph = 1'b1; tick_fast = 1'b1; tick_slow = 1'b0;
        wr(3'd0, C_EN | c_src(0));
        repeat (5) @(negedge clk);
        rd(3'd4, v); check("R4 source none frozen", v, 32'hFFFF_FFFF);
        wr(3'd0, C_EN | c_src(3));
        repeat (6) @(negedge clk);
        rd(3'd4, v); check("R4 slow source idle", v, 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) begin
            tick_slow = 1'b1; @(negedge clk);
            tick_slow = 1'b0; @(negedge clk);
        end
        rd(3'd4, v); check("R4 slow source pulses", v, 32'hFFFF_FFFA);
        wr(3'd0, C_EN | c_src(1) | c_pre(3));
        rd(3'd4, c0);
        repeat (8) @(negedge clk);
        rd(3'd4, v); check("R5 prescale 3 over 8 ticks", c0 - v, 32'd2);
        wr(3'd0, C_EN | c_src(2));
        rd(3'd4, c0);
        repeat (4) @(negedge clk);
        rd(3'd4, v); check("R4 fast source", c0 - v, 32'd4);
        wr(3'd0, 32'h0);
        tick_fast = 1'b0;
    endtask

    task automatic t_reload();
        logic [31:0] v;
        logic [31:0] exp [8] = '{32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0, 32'd5, 32'd4};
        wr(3'd2, 32'd5);
        wr(3'd0, C_EN | C_ENM | C_RLD | c_src(1));
        for (int i = 0; i < 8; i++) begin
            rd(3'd4, v);
            check(i == 0 ? "R8 preload on enable" : "R6 reload sequence", v, exp[i]);
            @(negedge clk);
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        logic [31:0] exp [4] = '{32'd1, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE};
        wr(3'd0, C_IOVW | c_src(1));
        wr(3'd2, 32'd2);
        rd(3'd4, v); check("R9 immediate load", v, 32'd2);
        wr(3'd0, C_IOVW | C_EN | c_src(1));
        rd(3'd4, v); check("R7 no preload without enable-mode", v, 32'd2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd(3'd4, v); check("R7 wrap sequence", v, exp[i]);
        end
        wr(3'd0, 32'h0);
    endtask

    task automatic t_compare();
        logic [31:0] v;
        wr(3'd1, 32'h1);
        wr(3'd2, 32'd5);
        wr(3'd3, 32'd3);
        rd(3'd1, v); check("R12 cleared before test", v, 32'h0);
        wr(3'd0, C_EN | C_ENM | C_RLD | c_src(1));
        @(negedge clk);
        rd(3'd1, v); check("R10 no flag before match", v, 32'h0);
        @(negedge clk);
        rd(3'd1, v); check("R10 flag on match, masked", v, 32'h1);
        check("R11 irq masked", 32'(irq), 32'h0);
        wr(3'd0, C_EN | C_ENM | C_RLD | C_IE | c_src(1));
        check("R11 irq unmasked", 32'(irq), 32'h1);
        repeat (4) @(negedge clk);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R12 set wins over clear", v, 32'h1);
        wr(3'd0, C_RLD | C_IE | c_src(1));
        check("R11 irq gated by enable", 32'(irq), 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R12 write zero ignored", v, 32'h1);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R12 write one clears", v, 32'h0);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        logic [31:0] cfg;
        cfg = C_EN | C_ENM | C_IE | C_RLD | c_pre(2) | C_IOVW | C_LP | c_src(1);
        wr(3'd0, cfg);
        wr(3'd2, 32'd9);
        wr(3'd3, 32'd7);
        repeat (10) @(negedge clk);
        wr(3'd0, cfg | C_SWR);
        rd(3'd0, v); check("R13 ctrl kept bits", v, 32'h003C_0003);
        rd(3'd1, v); check("R13 status cleared", v, 32'h0);
        rd(3'd2, v); check("R13 load all-ones", v, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R13 compare cleared", v, 32'h0);
        rd(3'd4, v); check("R13 count all-ones", v, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        rd(3'd4, v); check("R13 frozen after soft reset", v, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_sources();
        t_reload();
        t_wrap();
        t_compare();
        t_soft();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule